// File: doc/BRIEF.md
# Redundant Serial Link Selector

This block sits between a pair of redundant high-speed cell links and the cell router behind them. Each link delivers whole cells as single-cycle strobes. Each strobe comes with the cell's destination identifier and the active flag that the far end carries in the cell overhead. The block filters the far-end flag of each link over consecutive received cells and keeps a stored far-end status per link. It chooses one link as the working link, and it tells each transmit link whether to mark its outgoing cells as active or inactive.

The working link is chosen in one of two ways. In automatic mode the choice follows the filtered far-end status, and link one wins a tie. In forced mode the choice comes from a configuration bit. Received cells are then gated per link. The working link passes every cell. The other link passes only control-channel cells, which are recognised by a reserved destination identifier. The router receives one accepted-cell output per link, so both links can deliver a cell in the same cycle. The working link can only change in a cycle with no cell strobe on either link, so a cell is never split across links. The selected link and the stored far-end status are brought out for protection monitoring, and a one-cycle event pulse marks any change in them.

Top module: `redundant_link_sel`

## Requirements
- R1: The stored far-end status of a link (`far_stat[i]`) takes a new value only after `DEB_CELLS` (3 by default) consecutive cells on that link all carry that value. With fewer such cells it keeps its old value. The new value is visible the cycle after the last of those cells.
- R2: A received cell whose flag differs from the previous cell's flag on that link restarts the count. A run that is interrupted this way does not change the stored status.
- R3: Cycles without a cell strobe on a link neither advance nor clear that link's count, and they never change its stored status.
- R4: After reset, `far_stat` is 00, `sel_link` is 0 (link one working), `tx_act_flag` is 01, `acc_valid` is 00 and `stat_event` is 0.
- R5: In forced mode (`cfg_auto_sel`=0), `sel_link` follows `cfg_active`. `tx_act_flag[0]` is 1 and `tx_act_flag[1]` is 0 when `sel_link` is 0, and the reverse when it is 1.
- R6: In automatic mode the working link becomes link two (`sel_link`=1) only when `far_stat` is 10, that is, only link two reports active. When both links or neither link report active, link one is chosen.
- R7: A cell on the working link is accepted whatever its class. `acc_valid[i]` rises the cycle after the strobe and carries the cell's destination on `acc_dest[i*ID_W +: ID_W]`.
- R8: A cell on the non-working link is accepted only when its destination equals `CTRL_ID`. Any other cell on that link is dropped and `acc_valid[i]` stays 0.
- R9: A new working link takes effect only in a cycle with no strobe on either link. While strobes continue, `sel_link` holds its value. It updates at the first edge with no strobe.
- R10: `stat_event` is high for exactly the cycle in which `sel_link` or `far_stat` shows a new value, and it is low otherwise.
- R11: `acc_ctrl[i]` is 1 with an accepted cell whose destination equals `CTRL_ID`, and 0 with an accepted user cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto_sel | input | 1 | 1: automatic selection, 0: forced selection |
| cfg_active | input | 1 | Forced working link (0 = link one, 1 = link two) |
| rx_valid | input | 2 | Per-link whole-cell strobe |
| rx_far_act | input | 2 | Far-end active flag carried by each strobed cell |
| rx_dest | input | 2*ID_W | Destination identifier per link, link i at bits i*ID_W |
| acc_valid | output | 2 | Accepted cell per link, one cycle after the strobe |
| acc_ctrl | output | 2 | Accepted cell is a control-channel cell |
| acc_dest | output | 2*ID_W | Destination of the accepted cell per link |
| tx_act_flag | output | 2 | Active flag to insert into each transmit link's overhead |
| sel_link | output | 1 | Current working link |
| far_stat | output | 2 | Filtered far-end active status per link |
| stat_event | output | 1 | One-cycle pulse on any change of sel_link or far_stat |

## Verification
The bench builds the block with `ID_W`=4 and `CTRL_ID`=4'hA, and keeps `DEB_CELLS` at 3. A control identifier that is neither all zeros nor all ones shows that classification compares the full field. It also shows that neighbouring identifiers such as 4'hB stay user cells. With three-cell filtering, the bench can reach an interrupted run, a run split by idle cycles, and a filtered change that coincides with a strobe, each within a few cycles. That last case makes the deferred link change and the separate status events visible.

// File: rtl/rls_pkg.sv
package rls_pkg;

  typedef enum logic {
    LINK_ONE = 1'b0,
    LINK_TWO = 1'b1
  } link_e;

  // Working-link choice: forced bit, or far-end status with link one on ties.
  function automatic link_e pick_link(input logic auto_sel, input logic forced,
                                      input logic [1:0] far);
    if (!auto_sel) return link_e'(forced);
    if (far == 2'b10) return LINK_TWO;
    return LINK_ONE;
  endfunction

  // Class of a cell from its destination identifier.
  function automatic logic is_ctrl_dest(input logic [31:0] dest, input logic [31:0] ctrl_id);
    return dest == ctrl_id;
  endfunction

endpackage

// File: rtl/rls_debounce.sv
module rls_debounce #(
  parameter int DEB_CELLS = 3,
  localparam int CNT_W = $clog2(DEB_CELLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_v,
  input  logic flag,
  output logic stat,
  output logic stat_chg
);
  logic             last_q, last_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             stat_q, stat_n;

  always_comb begin
    last_n = last_q;
    cnt_n  = cnt_q;
    stat_n = stat_q;
    if (cell_v) begin
      if (flag != last_q) begin
        last_n = flag;
        cnt_n  = CNT_W'(1);
      end else if (cnt_q < CNT_W'(DEB_CELLS)) begin
        cnt_n = cnt_q + CNT_W'(1);
      end
      if (cnt_n >= CNT_W'(DEB_CELLS)) stat_n = flag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      last_q <= last_n;
      cnt_q  <= cnt_n;
      stat_q <= stat_n;
    end
  end

  assign stat     = stat_q;
  assign stat_chg = stat_n != stat_q;
endmodule

// File: rtl/rls_select.sv
module rls_select
  import rls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_sel,
  input  logic       forced,
  input  logic [1:0] far,
  input  logic       any_cell,
  output link_e      sel,
  output logic       sel_chg
);
  link_e cand;
  link_e sel_q;

  assign cand    = pick_link(auto_sel, forced, far);
  assign sel_chg = !any_cell && (cand != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= LINK_ONE;
    else if (sel_chg) sel_q <= cand;
  end

  assign sel = sel_q;
endmodule

// File: rtl/rls_gate.sv
module rls_gate
  import rls_pkg::*;
#(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] CTRL_ID = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cell_v,
  input  logic [ID_W-1:0] dest,
  input  logic            working,
  output logic            acc_v,
  output logic            acc_ctrl,
  output logic [ID_W-1:0] acc_dest
);
  logic ctrl_cell;
  logic pass;

  assign ctrl_cell = is_ctrl_dest(32'(dest), 32'(CTRL_ID));
  assign pass      = cell_v && (working || ctrl_cell);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_v    <= 1'b0;
      acc_ctrl <= 1'b0;
      acc_dest <= '0;
    end else begin
      acc_v <= pass;
      if (cell_v) begin
        acc_ctrl <= ctrl_cell;
        acc_dest <= dest;
      end
    end
  end
endmodule

// File: rtl/redundant_link_sel.sv
module redundant_link_sel
  import rls_pkg::*;
#(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] CTRL_ID = '1,
  parameter int DEB_CELLS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_sel,
  input  logic              cfg_active,
  input  logic [1:0]        rx_valid,
  input  logic [1:0]        rx_far_act,
  input  logic [2*ID_W-1:0] rx_dest,
  output logic [1:0]        acc_valid,
  output logic [1:0]        acc_ctrl,
  output logic [2*ID_W-1:0] acc_dest,
  output logic [1:0]        tx_act_flag,
  output logic              sel_link,
  output logic [1:0]        far_stat,
  output logic              stat_event
);
  localparam int NLINK = 2;

  logic [NLINK-1:0] far_chg;
  logic             sel_chg;
  link_e            sel;
  logic             evt_q;

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    rls_debounce #(.DEB_CELLS(DEB_CELLS)) u_deb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cell_v   (rx_valid[i]),
      .flag     (rx_far_act[i]),
      .stat     (far_stat[i]),
      .stat_chg (far_chg[i])
    );

    rls_gate #(.ID_W(ID_W), .CTRL_ID(CTRL_ID)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .cell_v   (rx_valid[i]),
      .dest     (rx_dest[i*ID_W +: ID_W]),
      .working  (sel == link_e'(i)),
      .acc_v    (acc_valid[i]),
      .acc_ctrl (acc_ctrl[i]),
      .acc_dest (acc_dest[i*ID_W +: ID_W])
    );
  end

  rls_select u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_sel (cfg_auto_sel),
    .forced   (cfg_active),
    .far      (far_stat),
    .any_cell (|rx_valid),
    .sel      (sel),
    .sel_chg  (sel_chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= sel_chg || (|far_chg);
  end

  assign sel_link    = sel;
  assign tx_act_flag = {sel == LINK_TWO, sel == LINK_ONE};
  assign stat_event  = evt_q;
endmodule

// File: rtl/rls_checker.sv
module rls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_auto_sel,
  input logic       cfg_active,
  input logic [1:0] rx_valid,
  input logic [1:0] acc_valid,
  input logic [1:0] acc_ctrl,
  input logic       sel_link,
  input logic [1:0] far_stat,
  input logic       stat_event
);
  AST_SEL_HELD_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> $stable(sel_link)); // R9

  AST_FAR0_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid[0] |=> $stable(far_stat[0])); // R3

  AST_FAR1_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid[1] |=> $stable(far_stat[1])); // R3

  AST_EVENT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_link) || !$stable(far_stat)) |-> stat_event); // R10

  AST_USER_ONLY_WORKING0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid[0] && !acc_ctrl[0]) |-> ($past(sel_link) == 1'b0)); // R8

  AST_USER_ONLY_WORKING1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid[1] && !acc_ctrl[1]) |-> ($past(sel_link) == 1'b1)); // R8

  AST_FORCED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_sel && !(|rx_valid)) |=> (sel_link == $past(cfg_active))); // R5
endmodule

bind redundant_link_sel rls_checker u_rls_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_auto_sel (cfg_auto_sel),
  .cfg_active   (cfg_active),
  .rx_valid     (rx_valid),
  .acc_valid    (acc_valid),
  .acc_ctrl     (acc_ctrl),
  .sel_link     (sel_link),
  .far_stat     (far_stat),
  .stat_event   (stat_event)
);

// File: tb/redundant_link_sel_tb_top.sv
module redundant_link_sel_tb_top;
  localparam int ID_W = 4;
  localparam logic [ID_W-1:0] CTRL = 4'hA;
  localparam int DEB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto_sel = 1'b1;
  logic cfg_active = 1'b0;
  logic [1:0] rx_valid = '0;
  logic [1:0] rx_far_act = '0;
  logic [2*ID_W-1:0] rx_dest = '0;
  logic [1:0] acc_valid, acc_ctrl, tx_act_flag, far_stat;
  logic [2*ID_W-1:0] acc_dest;
  logic sel_link, stat_event;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;

  always #5 clk = ~clk;

  redundant_link_sel #(.ID_W(ID_W), .CTRL_ID(CTRL), .DEB_CELLS(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_auto_sel(cfg_auto_sel), .cfg_active(cfg_active),
    .rx_valid(rx_valid), .rx_far_act(rx_far_act), .rx_dest(rx_dest),
    .acc_valid(acc_valid), .acc_ctrl(acc_ctrl), .acc_dest(acc_dest),
    .tx_act_flag(tx_act_flag), .sel_link(sel_link), .far_stat(far_stat),
    .stat_event(stat_event)
  );

  typedef struct packed {
    logic [1:0]        v;
    logic [1:0]        c;
    logic [2*ID_W-1:0] d;
  } exp_t;
  exp_t sb_q[$];

  // Bench model of the requirements.
  logic [1:0] m_last = '0;
  int         m_cnt[2] = '{0, 0};
  logic [1:0] m_far = '0;
  logic       m_sel = 1'b0;
  logic       m_evt = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one clock of stimulus, expected items pushed to the scoreboard.
  task automatic step(input logic [1:0] v, input logic [1:0] f,
                      input logic [ID_W-1:0] d0, input logic [ID_W-1:0] d1);
    exp_t e;
    logic [1:0] old_far;
    logic old_sel, want;
    @(negedge clk);
    rx_valid   = v;
    rx_far_act = f;
    rx_dest    = {d1, d0};
    e.d = {d1, d0};
    for (int i = 0; i < 2; i++) begin
      logic ctrl;
      ctrl   = ((i == 0 ? d0 : d1) == CTRL);
      e.c[i] = ctrl;
      e.v[i] = v[i] && ((m_sel == i[0]) || ctrl);
    end
    sb_q.push_back(e);
    old_far = m_far;
    old_sel = m_sel;
    for (int i = 0; i < 2; i++) begin
      if (v[i]) begin
        if (f[i] != m_last[i]) begin
          m_last[i] = f[i];
          m_cnt[i]  = 1;
        end else if (m_cnt[i] < DEB) begin
          m_cnt[i]++;
        end
        if (m_cnt[i] >= DEB) m_far[i] = f[i];
      end
    end
    if (v == 2'b00) begin
      if (!cfg_auto_sel) want = cfg_active;
      else want = (old_far == 2'b10);
      m_sel = want;
    end
    m_evt = (m_sel != old_sel) || (m_far != old_far);
    @(posedge clk);
    #1;
  endtask

  task automatic chk_status(input string tag);
    check({tag, " sel_link"}, 32'(sel_link), 32'(m_sel));
    check({tag, " far_stat"}, 32'(far_stat), 32'(m_far));
    check({tag, " tx_act_flag"}, 32'(tx_act_flag), 32'({m_sel, ~m_sel}));
    check({tag, " stat_event"}, 32'(stat_event), 32'(m_evt));
  endtask

  // Monitor: compares accepted cells against the scoreboard (R7 R8 R11).
  always @(posedge clk) begin
    #1;
    if (mon_en && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check("R7/R8 acc_valid", 32'(acc_valid), 32'(e.v));
      for (int i = 0; i < 2; i++) begin
        if (e.v[i]) begin
          check("R7 acc_dest", 32'(acc_dest[i*ID_W +: ID_W]), 32'(e.d[i*ID_W +: ID_W]));
          check("R11 acc_ctrl", 32'(acc_ctrl[i]), 32'(e.c[i]));
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R4 acc_valid", 32'(acc_valid), 32'(0));
    check("R4 far_stat", 32'(far_stat), 32'(0));
    check("R4 sel_link", 32'(sel_link), 32'(0));
    check("R4 tx_act_flag", 32'(tx_act_flag), 32'(2'b01));
    check("R4 stat_event", 32'(stat_event), 32'(0));
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;

    // R7 R8: link one working; link two user dropped, link two control passed.
    step(2'b11, 2'b00, 4'h3, 4'h5);
    step(2'b11, 2'b00, 4'hB, CTRL);
    step(2'b10, 2'b00, 4'h0, 4'hB);
    chk_status("R8");

    // R3: idle cycles between link-two cells do not disturb the count.
    step(2'b10, 2'b10, 4'h1, 4'h1);
    step(2'b00, 2'b00, 4'h0, 4'h0);
    step(2'b00, 2'b00, 4'h0, 4'h0);
    step(2'b10, 2'b10, 4'h1, 4'h1);
    chk_status("R3");
    // R2: a differing flag restarts the run.
    step(2'b10, 2'b00, 4'h1, 4'h1);
    step(2'b10, 2'b10, 4'h1, 4'h1);
    step(2'b10, 2'b10, 4'h1, 4'h1);
    chk_status("R2");
    // R1: third consecutive cell sets far_stat[1]; R10 event; R9 sel held.
    step(2'b10, 2'b10, 4'h1, 4'h1);
    chk_status("R1");
    check("R1 far_stat", 32'(far_stat), 32'(2'b10));
    step(2'b01, 2'b00, 4'h2, 4'h0);
    chk_status("R9");
    check("R9 sel held", 32'(sel_link), 32'(0));
    // R6 R9: first idle cycle switches to link two; R10 pulse lasts one cycle.
    step(2'b00, 2'b00, 4'h0, 4'h0);
    chk_status("R6");
    check("R6 sel link two", 32'(sel_link), 32'(1));
    check("R10 pulse", 32'(stat_event), 32'(1));
    step(2'b00, 2'b00, 4'h0, 4'h0);
    chk_status("R10");

    // R7 R8 with link two working.
    step(2'b11, 2'b10, 4'h4, 4'h6);
    step(2'b11, 2'b10, CTRL, 4'h7);
    chk_status("R7");

    // R6: both links active -> link one.
    step(2'b01, 2'b11, 4'h1, 4'h0);
    step(2'b01, 2'b11, 4'h1, 4'h0);
    step(2'b01, 2'b11, 4'h1, 4'h0);
    step(2'b00, 2'b00, 4'h0, 4'h0);
    chk_status("R6 both");
    check("R6 both sel", 32'(sel_link), 32'(0));

    // R5: forced mode overrides far-end status.
    cfg_auto_sel = 1'b0;
    cfg_active   = 1'b1;
    step(2'b00, 2'b00, 4'h0, 4'h0);
    chk_status("R5");
    check("R5 tx flags", 32'(tx_act_flag), 32'(2'b10));
    step(2'b11, 2'b00, 4'h8, 4'h9);
    cfg_active = 1'b0;
    step(2'b00, 2'b00, 4'h0, 4'h0);
    chk_status("R5 back");
    check("R5 tx flags back", 32'(tx_act_flag), 32'(2'b01));
    step(2'b00, 2'b00, 4'h0, 4'h0);
    step(2'b00, 2'b00, 4'h0, 4'h0);
    check("R11 queue drained", 32'(sb_q.size()), 32'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule